// File: doc/BRIEF.md
# Synchronization Preamble Symbol Sequencer

This block generates the stream of three-bit channel symbols that forms the synchronization preamble sent ahead of data in a single-tone serial modem. The preamble is a run of identical-length segments. Each segment holds fifteen symbols: a fixed nine-symbol acquisition pattern, two code symbols that announce the bit rate and interleave setting, three symbols that carry a countdown of the segments still to follow, and a trailing zero.

A request on `start` latches the interleave setting and the two code symbols, then the block offers symbols one at a time on a valid/ready handshake. The number of segments depends on the interleave setting: three for the zero and short settings, twenty-four for the long one. When the last symbol of the last segment has been taken, `done` rises and stays high until the next accepted start. Expanding symbols into tribit patterns, scrambling and modulation are handled by later stages.

Top module: `preamble_seq`

## Requirements
- R1: After reset, `sym_valid` and `done` are low and no symbol is offered.
- R2: A `start` pulse while idle makes `sym_valid` high on the next clock edge, with the first symbol of the first segment on `sym_data`.
- R3: Within each segment, symbol positions 0 to 8 and 14 are, in order, 0,1,3,0,1,3,1,2,0 and finally 0.
- R4: Positions 9 and 10 of every segment carry the `code_a` and `code_b` values latched at the accepted start.
- R5: Positions 11, 12 and 13 carry the segment countdown as a 6-bit word split into three 2-bit fields, most significant field first, each widened to 3 bits with a 1 in bit 2 (a count of 23 gives 5, 5, 7).
- R6: `ilv_mode` encoding: 2'b00 zero, 2'b01 short, 2'b1x long. Zero and short give 3 segments, long gives 24; the countdown starts at the segment count minus one and falls by one per segment to 0.
- R7: A symbol is consumed only on a clock edge where `sym_valid` and `sym_ready` are both high; while `sym_ready` is low the offered symbol holds.
- R8: `done` goes high on the edge that consumes the final symbol of the last segment, `sym_valid` goes low at the same edge, and `done` stays high until the next accepted start clears it.
- R9: A `start` while the preamble is in progress is ignored, and changes to `ilv_mode`, `code_a` and `code_b` after an accepted start do not alter the running preamble.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin a preamble |
| ilv_mode | input | 2 | Interleave setting: 00 zero, 01 short, 1x long |
| code_a | input | 3 | First rate/interleave code symbol |
| code_b | input | 3 | Second rate/interleave code symbol |
| sym_ready | input | 1 | Downstream accepts the offered symbol |
| sym_valid | output | 1 | A symbol is offered |
| sym_data | output | 3 | Offered channel symbol |
| done | output | 1 | Last preamble finished, held until next start |

## Verification
The sequence is run in each of the four interleave encodings, once with the consumer always ready and once with a pseudo-random ready pattern, so that the segment count (3 versus 24), the countdown field split and the stall behaviour are told apart. Distinct code symbol pairs, including all-zero and all-ones values, separate the code positions from the fixed pattern and the countdown. Mid-run start pulses with altered mode and code inputs show whether the latched values and position survive, and a start issued on the same cycle that `done` is seen checks a back-to-back restart.

// File: rtl/preamble_seq.sv
module preamble_seq #(
  parameter int SHORT_SEGS = 3,
  parameter int LONG_SEGS  = 24
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] ilv_mode,
  input  logic [2:0] code_a,
  input  logic [2:0] code_b,
  input  logic       sym_ready,
  output logic       sym_valid,
  output logic [2:0] sym_data,
  output logic       done
);
  localparam int CW      = 6;
  localparam int PW      = 4;
  localparam int LAST_POS = 14;

  logic          busy;
  logic [PW-1:0] pos;
  logic [CW-1:0] cnt;
  logic [2:0]    d1_q, d2_q;
  logic          accept, seg_end, run_end;

  assign sym_valid = busy;
  assign accept    = busy & sym_ready;
  assign seg_end   = (pos == PW'(LAST_POS));
  assign run_end   = seg_end && (cnt == '0);

  always_comb begin
    case (pos)
      4'd1, 4'd4, 4'd6: sym_data = 3'd1;
      4'd2, 4'd5:       sym_data = 3'd3;
      4'd7:             sym_data = 3'd2;
      4'd9:             sym_data = d1_q;
      4'd10:            sym_data = d2_q;
      4'd11:            sym_data = {1'b1, cnt[5:4]};
      4'd12:            sym_data = {1'b1, cnt[3:2]};
      4'd13:            sym_data = {1'b1, cnt[1:0]};
      default:          sym_data = 3'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      pos  <= '0;
      cnt  <= '0;
      d1_q <= '0;
      d2_q <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        done <= 1'b0;
        pos  <= '0;
        cnt  <= ilv_mode[1] ? CW'(LONG_SEGS - 1) : CW'(SHORT_SEGS - 1);
        d1_q <= code_a;
        d2_q <= code_b;
      end
    end else if (accept) begin
      if (run_end) begin
        busy <= 1'b0;
        done <= 1'b1;
        pos  <= '0;
      end else if (seg_end) begin
        pos <= '0;
        cnt <= cnt - 1'b1;
      end else begin
        pos <= pos + 1'b1;
      end
    end
  end
endmodule

module preamble_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       sym_ready,
  input logic       sym_valid,
  input logic [2:0] sym_data,
  input logic       done,
  input logic [3:0] pos,
  input logic [5:0] cnt
);
  p_idle_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && sym_valid));

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sym_valid && start) |=> (sym_valid && pos == 4'd0 && !done));

  p_cnt_msb_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && pos >= 4'd11 && pos <= 4'd13) |-> sym_data[2]);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && !sym_ready) |=> (sym_valid && $stable(sym_data) && $stable(pos) && $stable(cnt)));

  p_finish_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && sym_ready && pos == 4'd14 && cnt == 6'd0) |=> (done && !sym_valid));

  p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  p_busy_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && start && sym_ready && pos < 4'd14) |=> (sym_valid && pos == $past(pos) + 4'd1));
endmodule

bind preamble_seq preamble_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .sym_ready(sym_ready),
  .sym_valid(sym_valid), .sym_data(sym_data), .done(done),
  .pos(pos), .cnt(cnt)
);

// File: tb/preamble_seq_bench.sv
module preamble_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [1:0] ilv_mode = 2'b00;
  logic [2:0] code_a = 3'd0;
  logic [2:0] code_b = 3'd0;
  logic       sym_ready = 1'b0;
  logic       sym_valid;
  logic [2:0] sym_data;
  logic       done;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  int accepted = 0;
  bit rnd_ready = 0;
  bit exp_done = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [2:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  preamble_seq u_preamble_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .ilv_mode(ilv_mode),
    .code_a(code_a), .code_b(code_b), .sym_ready(sym_ready),
    .sym_valid(sym_valid), .sym_data(sym_data), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cycles);
    end
  endtask

  function automatic void fill(input logic [1:0] m, input logic [2:0] a, input logic [2:0] b);
    int nseg = m[1] ? 24 : 3;
    int pat[9] = '{0, 1, 3, 0, 1, 3, 1, 2, 0};
    for (int s = nseg - 1; s >= 0; s--) begin
      for (int i = 0; i < 9; i++) begin exp_q.push_back(3'(pat[i])); tag_q.push_back("R3"); end
      exp_q.push_back(a); tag_q.push_back("R4");
      exp_q.push_back(b); tag_q.push_back("R4");
      exp_q.push_back(3'(4 + (s / 16))); tag_q.push_back("R5");
      exp_q.push_back(3'(4 + ((s / 4) % 4))); tag_q.push_back("R5");
      exp_q.push_back(3'(4 + (s % 4))); tag_q.push_back("R5");
      exp_q.push_back(3'd0); tag_q.push_back("R3");
    end
  endfunction

  task automatic step(input bit st, input logic [1:0] m, input logic [2:0] a, input logic [2:0] b);
    bit ev, rdy;
    @(negedge clk);
    cycles++;
    ev = (exp_q.size() > 0);
    check(sym_valid == ev, "R7 valid", int'(sym_valid), int'(ev));
    if (ev && sym_valid) check(sym_data == exp_q[0], tag_q[0], int'(sym_data), int'(exp_q[0]));
    check(done == exp_done, "R8 done", int'(done), int'(exp_done));
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    rdy = rnd_ready ? (lfsr[0] | lfsr[3]) : 1'b1;
    sym_ready = rdy;
    start = st; ilv_mode = m; code_a = a; code_b = b;
    if (ev && rdy) begin
      void'(exp_q.pop_front()); void'(tag_q.pop_front());
      accepted++;
      if (exp_q.size() == 0) exp_done = 1;
    end else if (!ev && st) begin
      fill(m, a, b);
      exp_done = 0;
      accepted = 0;
    end
  endtask

  task automatic run(input logic [1:0] m, input logic [2:0] a, input logic [2:0] b, input bit inject);
    int n = 0;
    step(1'b1, m, a, b);
    step(1'b0, m, a, b);
    check(sym_valid == 1'b1, "R2 start", int'(sym_valid), 1);
    while (!exp_done && n < 2000) begin
      n++;
      if (inject && (n == 20 || n == 77))
        step(1'b1, ~m, ~a, ~b);
      else
        step(1'b0, inject ? ~m : m, inject ? 3'(a + 3'd3) : a, b);
    end
    check(accepted == (m[1] ? 360 : 45), "R6 symbol count", accepted, m[1] ? 360 : 45);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(sym_valid == 1'b0, "R1 valid", int'(sym_valid), 0);
    check(done == 1'b0, "R1 done", int'(done), 0);
    rst_n = 1'b1;
    step(1'b0, 2'b00, 3'd0, 3'd0);
    rnd_ready = 0; run(2'b00, 3'd7, 3'd4, 1'b0);
    step(1'b0, 2'b00, 3'd0, 3'd0);
    step(1'b0, 2'b00, 3'd0, 3'd0);
    rnd_ready = 1; run(2'b01, 3'd5, 3'd2, 1'b1);
    rnd_ready = 1; run(2'b10, 3'd6, 3'd3, 1'b0);
    rnd_ready = 0; run(2'b11, 3'd0, 3'd1, 1'b1);
    rnd_ready = 1; run(2'b00, 3'd7, 3'd7, 1'b0);
    repeat (4) step(1'b0, 2'b00, 3'd0, 3'd0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    fails++; tests++;
    $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule